// File: doc/BRIEF.md
# Oversampled serial byte receiver with sticky framing-error status

The block receives asynchronous serial frames on a single line. A one-cycle enable, pulsing at sixteen times the bit rate, sets the pace. Each frame holds one start bit, eight data bits sent least significant bit first, and one or two stop bits. Every complete frame lands in a receive data register. A good frame raises a data-full flag. A frame whose first stop bit samples low raises a sticky framing-error flag instead. While that flag stands, the receiver accepts no new frames.

Software reaches both registers through a small register port with one address bit. Address 0 selects status and address 1 selects the received byte. A flag is cleared only by a two-step handshake: a status read that returns the flag as 1, then a status write with that flag's bit at 0. The standby input drops both flags at once and stops any frame in progress. The receive-enable input gates reception without touching either flag.

Top module: `serial_rx_stat`

## Requirements
- R1: After reset both status flags read 0, the data register reads 0x00 and the receiver waits for a start bit.
- R2: A low level on the line counts as a start bit only if the line is still low 8 ticks after the tick that detected it. A shorter low pulse returns the receiver to idle and produces no frame.
- R3: Data bits are sampled once each, 16 ticks apart, starting 16 ticks after the start-bit check, and assembled least significant bit first. A frame whose first stop bit samples 1 writes the byte to the data register (address 1) and sets the data-full flag, status bit 0.
- R4: A frame whose first stop bit samples 0 still writes the byte to the data register. It leaves status bit 0 unchanged and sets the framing-error flag, status bit 1. Only a frame can set this bit.
- R5: When the two-stop-bit input is 1, the first stop bit is checked and the second is never checked: a low second stop bit raises no error.
- R6: While status bit 1 is 1, start bits on the line are ignored and the data register and status bit 0 keep their values.
- R7: A status flag clears only when a status write (address 0) carries a 0 in that flag's bit and a status read returned the flag as 1 since the previous status write. Every status write disarms both flags. Writing 1 never sets a flag.
- R8: While standby is 1, both flags are cleared on the next clock and any frame in progress is abandoned.
- R9: With receive enable at 0, no frame is received and both flags keep their values.
- R10: If a frame completes in the same cycle as an armed clearing write to the flag that the frame sets, the flag ends at 1.
- R11: The receiver advances only on cycles where the tick input is 1. Pausing the ticks stretches the frame without corrupting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Standby request; clears flags and aborts reception |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversample enable, 16 per bit period |
| rx_en_i | input | 1 | Receive enable |
| two_stop_i | input | 1 | 1 selects two stop bits |
| reg_addr_i | input | 1 | 0 = status, 1 = receive data |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 2 | Status write data: bit 0 data-full, bit 1 framing error |
| reg_rdata_o | output | 8 | Read data for the selected register |
| rdf_o | output | 1 | Data-full flag |
| fer_o | output | 1 | Framing-error flag |

## Verification
Two events can land in the same cycle: the stop-bit sample that sets a flag, and an armed software write that clears that same flag. The bench reads status so that the data-full flag is armed, then sends a good frame. It watches its own model's tick count and issues the clearing write exactly on the edge where the stop bit is sampled. The flag must then read 1, and a later write of 0 with no read in between must leave it at 1, which shows the write also disarmed it.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP1, RX_STOP2
  } rx_state_e;

  localparam int unsigned STAT_W   = 2;
  localparam int unsigned FLAG_RDF = 0;
  localparam int unsigned FLAG_FER = 1;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned OVS      = 16,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              hold_i,
  input  logic              two_stop_i,
  output logic              start_o,
  output logic              done_o,
  output logic              stop_ok_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic [SYNC_STG-1:0] sync_q;
  logic                rx_s;
  rx_state_e           state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic [DATA_W-1:0]   shift_q, shift_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STG-2:0], rx_i};
  end
  assign rx_s = sync_q[SYNC_STG-1];

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    bit_d     = bit_q;
    shift_d   = shift_q;
    start_o   = 1'b0;
    done_o    = 1'b0;
    stop_ok_o = 1'b0;
    if (standby_i || !en_i) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
      unique case (state_q)
        RX_IDLE: begin
          cnt_d = '0;
          if (!rx_s && !hold_i) begin
            state_d = RX_START;
            start_o = 1'b1;
          end
        end
        RX_START: if (cnt_q == CNT_MID) begin
          cnt_d   = '0;
          bit_d   = '0;
          state_d = rx_s ? RX_IDLE : RX_DATA;
        end
        RX_DATA: if (cnt_q == CNT_LAST) begin
          cnt_d   = '0;
          shift_d = {rx_s, shift_q[DATA_W-1:1]};
          if (bit_q == BIT_LAST) state_d = RX_STOP1;
          else                   bit_d   = bit_q + 1'b1;
        end
        RX_STOP1: if (cnt_q == CNT_LAST) begin
          cnt_d     = '0;
          done_o    = 1'b1;
          stop_ok_o = rx_s;
          state_d   = two_stop_i ? RX_STOP2 : RX_IDLE;
        end
        RX_STOP2: if (cnt_q == CNT_LAST) begin
          cnt_d   = '0;
          state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
    end
  end

  assign data_o = shift_q;
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic              stop_ok_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [STAT_W-1:0] flags_o
);
  logic              wr_stat, rd_stat;
  logic [STAT_W-1:0] flag_q, flag_d, arm_q, arm_d, set_ev;
  logic [DATA_W-1:0] rdr_q;

  assign wr_stat = wr_i && (addr_i == ADDR_STAT);
  assign rd_stat = rd_i && (addr_i == ADDR_STAT);
  assign set_ev[FLAG_RDF] = done_i &&  stop_ok_i;
  assign set_ev[FLAG_FER] = done_i && !stop_ok_i;

  for (genvar g = 0; g < STAT_W; g++) begin : g_flag
    always_comb begin
      flag_d[g] = flag_q[g];
      arm_d[g]  = arm_q[g];
      if (wr_stat) begin
        arm_d[g] = 1'b0;
        if (arm_q[g] && !wdata_i[g]) flag_d[g] = 1'b0;
      end else if (rd_stat && flag_q[g]) begin
        arm_d[g] = 1'b1;
      end
      if (set_ev[g]) flag_d[g] = 1'b1;  // hardware set wins
      if (standby_i) begin
        flag_d[g] = 1'b0;
        arm_d[g]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      arm_q  <= '0;
      rdr_q  <= '0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
      if (done_i) rdr_q <= data_i;
    end
  end

  assign rdata_o = (addr_i == ADDR_DATA) ? rdr_q : DATA_W'(flag_q);
  assign flags_o = flag_q;
endmodule

// File: rtl/serial_rx_stat.sv
module serial_rx_stat
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned OVS      = 16,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              rx_en_i,
  input  logic              two_stop_i,
  input  logic              reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              rdf_o,
  output logic              fer_o
);
  logic              start_w, done_w, stop_ok_w;
  logic [DATA_W-1:0] data_w;
  logic [STAT_W-1:0] flags_w;

  serial_rx_core #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STG(SYNC_STG)) u_core (
    .clk_i, .rst_ni, .standby_i, .rx_i, .tick_i,
    .en_i       (rx_en_i),
    .hold_i     (flags_w[FLAG_FER]),
    .two_stop_i,
    .start_o    (start_w),
    .done_o     (done_w),
    .stop_ok_o  (stop_ok_w),
    .data_o     (data_w)
  );

  serial_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .standby_i,
    .addr_i    (reg_addr_i),
    .rd_i      (reg_rd_i),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .done_i    (done_w),
    .stop_ok_i (stop_ok_w),
    .data_i    (data_w),
    .rdata_o   (reg_rdata_o),
    .flags_o   (flags_w)
  );

  assign rdf_o = flags_w[FLAG_RDF];
  assign fer_o = flags_w[FLAG_FER];
endmodule

// File: rtl/serial_rx_stat_chk.sv
module serial_rx_stat_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       standby_i,
  input logic       rx_en_i,
  input logic       reg_addr_i,
  input logic       reg_wr_i,
  input logic [1:0] reg_wdata_i,
  input logic       rdf_o,
  input logic       fer_o,
  input logic       start_w,
  input logic       done_w,
  input logic       stop_ok_w
);
  AST_FER_HW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fer_o) |-> $past(done_w && !stop_ok_w)); // R4
  AST_FER_CLR_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fer_o) && !$past(standby_i) |-> $past(reg_wr_i && !reg_addr_i && !reg_wdata_i[1])); // R7
  AST_RDF_CLR_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdf_o) && !$past(standby_i) |-> $past(reg_wr_i && !reg_addr_i && !reg_wdata_i[0])); // R7
  AST_ERR_BLOCKS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fer_o |-> !start_w); // R6
  AST_STANDBY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> !fer_o && !rdf_o); // R8
  AST_DISABLED_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |-> !start_w && !done_w); // R9
  AST_GOOD_SETS_RDF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w && stop_ok_w |=> rdf_o); // R10
  AST_BAD_SETS_FER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w && !stop_ok_w |=> fer_o); // R4
endmodule

bind serial_rx_stat serial_rx_stat_chk u_chk (
  .clk_i, .rst_ni, .standby_i, .rx_en_i, .reg_addr_i, .reg_wr_i, .reg_wdata_i,
  .rdf_o, .fer_o,
  .start_w   (start_w),
  .done_w    (done_w),
  .stop_ok_w (stop_ok_w)
);

// File: tb/sim_serial_rx_stat.sv
`timescale 1ns/1ps
module sim_serial_rx_stat;
  logic       clk_i = 1'b0, rst_ni = 1'b0, standby_i = 1'b0, rx_i = 1'b1;
  logic       tick_i = 1'b0, rx_en_i = 1'b1, two_stop_i = 1'b0;
  logic       reg_addr_i = 1'b0, reg_rd_i = 1'b0, reg_wr_i = 1'b0;
  logic [1:0] reg_wdata_i = 2'b00;
  logic [7:0] reg_rdata_o;
  logic       rdf_o, fer_o;

  int nchk = 0, nerr = 0, cyc = 0, div = 0;
  logic tick_pause = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  serial_rx_stat u0 (.*);

  always @(negedge clk_i) begin
    if (tick_pause) tick_i <= 1'b0;
    else begin
      tick_i <= (div == 1);
      div    <= (div == 1) ? 0 : div + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic       m_rdf = 0, m_fer = 0, m_arm_r = 0, m_arm_f = 0, m_busy = 0;
  logic [7:0] m_rdr = 0, m_sh = 0;
  int         m_t = 0;
  logic       rxq[$] = '{1'b1, 1'b1};

  always @(posedge clk_i) begin
    logic rxs, sr, sf;
    if (!rst_ni) begin
      m_rdf = 0; m_fer = 0; m_arm_r = 0; m_arm_f = 0; m_busy = 0;
      m_rdr = 0; m_sh = 0; m_t = 0; rxq = '{1'b1, 1'b1};
    end else begin
      rxs = rxq[0];
      rxq.push_back(rx_i);
      void'(rxq.pop_front());
      sr = 0; sf = 0;
      if (standby_i) begin
        m_busy = 0; m_rdf = 0; m_fer = 0; m_arm_r = 0; m_arm_f = 0;
      end else begin
        if (!rx_en_i) m_busy = 0;
        else if (tick_i) begin
          if (!m_busy) begin
            if (!rxs && !m_fer) begin m_busy = 1; m_t = 0; end
          end else begin
            m_t++;
            if (m_t == 8 && rxs) m_busy = 0;
            else if (m_t >= 24 && m_t <= 136 && (m_t - 24) % 16 == 0) m_sh[(m_t - 24) / 16] = rxs;
            else if (m_t == 152) begin
              m_rdr = m_sh;
              if (rxs) sr = 1; else sf = 1;
              if (!two_stop_i) m_busy = 0;
            end else if (m_t == 168) m_busy = 0;
          end
        end
        if (reg_wr_i && !reg_addr_i) begin
          if (m_arm_r && !reg_wdata_i[0]) m_rdf = 0;
          if (m_arm_f && !reg_wdata_i[1]) m_fer = 0;
          m_arm_r = 0; m_arm_f = 0;
        end else if (reg_rd_i && !reg_addr_i) begin
          if (m_rdf) m_arm_r = 1;
          if (m_fer) m_arm_f = 1;
        end
        if (sr) m_rdf = 1;
        if (sf) m_fer = 1;
      end
    end
  end

  // per-cycle comparison
  always begin
    @(posedge clk_i);
    #2;
    cyc++;
    if (rst_ni) begin
      chk("R3 rdf", rdf_o, m_rdf);
      chk("R4 fer", fer_o, m_fer);
      chk("R7 rdata", reg_rdata_o, reg_addr_i ? m_rdr : {6'b0, m_fer, m_rdf});
    end
  end

  task automatic hold_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk_i);
      if (tick_i) k++;
      @(negedge clk_i);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic s1, input logic two, input logic s2);
    rx_i = 0; hold_ticks(16);
    for (int i = 0; i < 8; i++) begin rx_i = b[i]; hold_ticks(16); end
    rx_i = s1; hold_ticks(16);
    if (two) begin rx_i = s2; hold_ticks(16); end
    rx_i = 1; hold_ticks(24);
  endtask

  task automatic rd_stat();
    reg_addr_i = 0; reg_rd_i = 1; @(negedge clk_i); reg_rd_i = 0;
  endtask

  task automatic wr_stat(input logic [1:0] d);
    reg_addr_i = 0; reg_wdata_i = d; reg_wr_i = 1; @(negedge clk_i); reg_wr_i = 0;
  endtask

  task automatic peek(input logic a, input logic [7:0] exp, input string tag);
    reg_addr_i = a; #1; chk(tag, reg_rdata_o, exp);
  endtask

  task automatic clear_both();
    rd_stat(); wr_stat(2'b00); @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    peek(0, 8'h00, "R1 status after reset");
    peek(1, 8'h00, "R1 data after reset");

    send_frame(8'hA5, 1, 0, 1);
    peek(0, 8'h01, "R3 good frame status");
    peek(1, 8'hA5, "R3 good frame data");
    clear_both();
    peek(0, 8'h00, "R7 rdf cleared by handshake");

    send_frame(8'h3C, 0, 0, 1);
    peek(0, 8'h02, "R4 bad stop status");
    peek(1, 8'h3C, "R4 bad stop data stored");

    wr_stat(2'b00); @(negedge clk_i);
    peek(0, 8'h02, "R7 write0 without read");
    rd_stat(); wr_stat(2'b11); @(negedge clk_i);
    peek(0, 8'h02, "R7 write1 no clear");
    wr_stat(2'b00); @(negedge clk_i);
    peek(0, 8'h02, "R7 write disarms");

    send_frame(8'h11, 1, 0, 1);
    peek(0, 8'h02, "R6 frame ignored status");
    peek(1, 8'h3C, "R6 frame ignored data");

    rx_en_i = 0; repeat (4) @(negedge clk_i);
    peek(0, 8'h02, "R9 enable off keeps fer");
    rx_en_i = 1;
    clear_both();
    peek(0, 8'h00, "R7 fer cleared by handshake");

    rx_en_i = 0;
    send_frame(8'h77, 1, 0, 1);
    peek(0, 8'h00, "R9 no frame while disabled");
    peek(1, 8'h3C, "R9 data unchanged while disabled");
    rx_en_i = 1;

    rx_i = 0; hold_ticks(4); rx_i = 1; hold_ticks(200);
    peek(0, 8'h00, "R2 short low pulse rejected");
    peek(1, 8'h3C, "R2 data unchanged after glitch");

    two_stop_i = 1;
    send_frame(8'h5A, 1, 1, 0);
    peek(0, 8'h01, "R5 second stop not checked");
    peek(1, 8'h5A, "R5 two-stop data");
    clear_both();
    send_frame(8'h0F, 0, 1, 1);
    peek(0, 8'h02, "R5 first stop still checked");
    clear_both();
    two_stop_i = 0;

    fork
      send_frame(8'hC3, 1, 0, 1);
      begin
        hold_ticks(60); tick_pause = 1;
        repeat (50) @(negedge clk_i);
        tick_pause = 0;
      end
    join
    peek(0, 8'h01, "R11 paused ticks status");
    peek(1, 8'hC3, "R11 paused ticks data");

    rd_stat();
    fork
      send_frame(8'h96, 1, 0, 1);
      begin
        for (int w = 0; w < 2000; w++) begin
          @(negedge clk_i); #1;
          if (m_busy && m_t == 151 && tick_i) begin
            reg_addr_i = 0; reg_wdata_i = 2'b00; reg_wr_i = 1;
            @(negedge clk_i); reg_wr_i = 0;
            break;
          end
        end
      end
    join
    peek(0, 8'h01, "R10 set wins over clear");
    peek(1, 8'h96, "R10 data");
    wr_stat(2'b00); @(negedge clk_i);
    peek(0, 8'h01, "R10 collision write disarmed");

    send_frame(8'hE1, 0, 0, 1);
    peek(0, 8'h03, "R8 both flags before standby");
    standby_i = 1; @(negedge clk_i); standby_i = 0;
    peek(0, 8'h00, "R8 standby clears flags");

    repeat (4) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    nchk++; nerr++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule